// File: doc/BRIEF.md
# Permutation Table Loader for Iterative Decoding

This block keeps two equal-sized lookup tables of 13-bit indices, one holding a frame permutation and the other holding its inverse. Before a decode starts, an external agent configures the frame length and then streams the permutation in, one index per accepted cycle. Each value lands in the forward table at the position given by its arrival count. In the same cycle, the arrival count is written into the inverse table at the position named by the value. When the stream ends, both tables are complete and consistent, and no second pass over the data is needed.

During decoding, the surrounding datapath asks for the storage address of each extrinsic value. In the first half-iteration it reads the forward table, and in the second half-iteration it reads the inverse table. A one-bit select picks the table, and the answer comes back one cycle after the request. The permutation itself is always produced outside the block.

Top module: `perm_table_loader`

## Requirements
- R1: After reset, `load_done` and `rd_valid` are 0.
- R2: A `load_start` pulse is taken only when `frame_len` lies in 40..5114. It then clears `load_done` and opens a load of `frame_len` entries. A pulse with any other length is ignored: `load_done` and the tables keep their state.
- R3: The k-th value accepted during a load (counting from 0, counting only cycles with `seq_valid` high) is written to forward table entry k.
- R4: In the same cycle, inverse table entry v receives k, where v is the accepted value. For a permutation this gives inverse[forward[k]] == k for every k below the frame length.
- R5: `load_done` rises in the cycle after the last of the `frame_len` values is accepted. It stays high until the next legal `load_start`.
- R6: A read request (`rd_en` high) with `rd_sel` = 0 returns forward entry `rd_idx`, and with `rd_sel` = 1 returns inverse entry `rd_idx`. The result is on `rd_data` in the following cycle, with `rd_valid` high. `rd_valid` is low in any cycle that follows a cycle without a request.
- R7: Values presented on `seq_valid` while no load is open change neither table.
- R8: A legal `load_start` during an open load restarts the count at 0, so the next accepted value goes to forward entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_len | input | 13 | Frame length sampled on `load_start` |
| load_start | input | 1 | Opens a new load |
| seq_valid | input | 1 | A permutation value is present |
| seq_data | input | 13 | Permutation value |
| load_done | output | 1 | Both tables are filled for the current frame |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0: forward table, 1: inverse table |
| rd_idx | input | 13 | Table entry to read |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | 13 | Read result |

## Verification
The assertions check the following on every cycle:
- the fill counter stays below the latched frame length while a load is open;
- a load is never open while `load_done` is high;
- `load_done` follows the last accepted value by exactly one cycle;
- an illegal start leaves the state alone, and a legal start re-arms the count;
- `rd_valid` tracks the previous cycle's request.

Only the bench scenarios can show what the tables actually hold. The bench streams shuffled permutations at the minimum length, at a mid length with idle gaps, at the maximum length and after an interrupted load. It then reads every forward entry and the inverse entry at each permuted position, and it also checks that stray values and rejected starts leave the contents intact.

// File: rtl/perm_tbl_pkg.sv
// Package: shared constants and types for the permutation table loader.
// Assumes a 13-bit index space, enough for frames of up to 8191 entries.
package perm_tbl_pkg;
    localparam int IDX_BITS = 13;

    // Selects which table a read request targets.
    typedef enum logic {
        TBL_FWD = 1'b0,
        TBL_INV = 1'b1
    } tbl_sel_e;
endpackage

// File: rtl/perm_fill_ctrl.sv
// Fill controller: accepts a legal start, counts the accepted sequence
// values and produces a write strobe with the arrival index. It raises
// done after the configured number of values.
// Assumes frame lengths outside MIN_LEN..MAX_LEN are requests to be ignored.
module perm_fill_ctrl #(
    parameter int IDX_W   = 13,
    parameter int MIN_LEN = 40,
    parameter int MAX_LEN = 5114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] frame_len,
    input  logic             load_start,
    input  logic             seq_valid,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_pos,
    output logic             done
);
    localparam logic [IDX_W-1:0] MIN_V = IDX_W'(MIN_LEN);
    localparam logic [IDX_W-1:0] MAX_V = IDX_W'(MAX_LEN);

    logic             loading;
    logic [IDX_W-1:0] count;
    logic [IDX_W-1:0] len_q;
    logic             len_ok;
    logic             start_ok;
    logic             last_one;

    // Decide whether the offered start is acceptable and whether this write closes the load.
    always_comb begin
        len_ok   = (frame_len >= MIN_V) && (frame_len <= MAX_V);
        start_ok = load_start && len_ok;
        wr_en    = loading && seq_valid && !start_ok;
        wr_pos   = count;
        last_one = (count == len_q - 1'b1);
    end

    // Track the load state, the arrival count and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loading <= 1'b0;
            count   <= '0;
            len_q   <= '0;
            done    <= 1'b0;
        end else if (start_ok) begin
            loading <= 1'b1;
            count   <= '0;
            len_q   <= frame_len;
            done    <= 1'b0;
        end else if (wr_en) begin
            count <= count + 1'b1;
            if (last_one) begin
                loading <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> (count < len_q));
    a_r2_illegal_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (load_start && !len_ok && !loading) |=> (!loading && done == $past(done)));
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last_one) |=> (done && !loading));
    a_r5_done_excludes_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && loading));
    a_r8_restart_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (loading && count == '0 && !done));
endmodule

// File: rtl/perm_table_ram.sv
// Table storage: one write port and one registered read port.
// A read and a write to the same entry in one cycle return the old contents.
// Writes or reads outside DEPTH are dropped or return zero.
module perm_table_ram #(
    parameter int W     = 13,
    parameter int DEPTH = 5114
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic         re,
    input  logic [W-1:0] raddr,
    output logic [W-1:0] rdata
);
    localparam logic [W-1:0] LIMIT = W'(DEPTH);

    logic [W-1:0] mem [DEPTH];

    // Store an entry when the address is inside the table.
    always_ff @(posedge clk) begin
        if (we && (waddr < LIMIT)) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the requested entry for the read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= (raddr < LIMIT) ? mem[raddr] : '0;
        end
    end
endmodule

// File: rtl/perm_read_port.sv
// Read port: delays the request flag and table select by one cycle to
// line up with the registered table outputs, then picks one table.
// Assumes both tables are read every requested cycle at the same index.
module perm_read_port
    import perm_tbl_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] fwd_q,
    input  logic [IDX_W-1:0] inv_q,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_data
);
    tbl_sel_e sel_q;

    // Remember which table was asked for and whether a request was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            sel_q    <= TBL_FWD;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                sel_q <= tbl_sel_e'(rd_sel);
            end
        end
    end

    // Present the selected table's output.
    always_comb begin
        rd_data = (sel_q == TBL_INV) ? inv_q : fwd_q;
    end

    a_r6_valid_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r6_no_valid_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/perm_table_loader.sv
// Top: loads a permutation and its inverse from one serial stream and
// serves lookups from either table. Forward entry k gets the k-th value.
// The inverse table gets k at address value (address and data swapped).
// Assumes the stream is a true permutation of 0..frame_len-1.
module perm_table_loader
    import perm_tbl_pkg::*;
#(
    parameter int IDX_W   = IDX_BITS,
    parameter int DEPTH   = 5114,
    parameter int MIN_LEN = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] frame_len,
    input  logic             load_start,
    input  logic             seq_valid,
    input  logic [IDX_W-1:0] seq_data,
    output logic             load_done,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_data
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_pos;
    logic [IDX_W-1:0] fwd_q;
    logic [IDX_W-1:0] inv_q;

    perm_fill_ctrl #(
        .IDX_W  (IDX_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_len (frame_len),
        .load_start(load_start),
        .seq_valid (seq_valid),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos),
        .done      (load_done)
    );

    // Forward table: address is the arrival position, data is the value.
    perm_table_ram #(.W(IDX_W), .DEPTH(DEPTH)) u_fwd (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(wr_pos),
        .wdata(seq_data),
        .re   (rd_en),
        .raddr(rd_idx),
        .rdata(fwd_q)
    );

    // Inverse table: address is the value, data is the arrival position.
    perm_table_ram #(.W(IDX_W), .DEPTH(DEPTH)) u_inv (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(seq_data),
        .wdata(wr_pos),
        .re   (rd_en),
        .raddr(rd_idx),
        .rdata(inv_q)
    );

    perm_read_port #(.IDX_W(IDX_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .fwd_q   (fwd_q),
        .inv_q   (inv_q),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    a_r7_writes_need_value: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> seq_valid);
    a_r5_done_rises_on_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> $past(seq_valid));
endmodule

// File: tb/perm_table_loader_bench.sv
// Scoreboard bench: a driver task queues expected read results, and a
// monitor compares each rd_valid result against the queue head.
module perm_table_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN       = 5114;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] frame_len = '0;
    logic        load_start = 1'b0;
    logic        seq_valid = 1'b0;
    logic [12:0] seq_data = '0;
    logic        load_done;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [12:0] rd_idx = '0;
    logic        rd_valid;
    logic [12:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    int    perm [MAXN];
    int    q_exp [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_table_loader u_perm_table_loader (
        .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .load_start(load_start),
        .seq_valid(seq_valid), .seq_data(seq_data), .load_done(load_done),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_exp.size() == 0) begin
                check("R6 unexpected rd_valid", 1, 0);
            end else begin
                check(q_tag.pop_front(), int'(rd_data), q_exp.pop_front());
            end
        end
    end

    task automatic rd(input int idx, input bit sel, input int exp, input string tag);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = sel;
        rd_idx = 13'(idx);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic rd_drain();
        @(negedge clk);
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", q_exp.size(), 0);
    endtask

    task automatic shuffle(input int n);
        for (int i = 0; i < n; i++) perm[i] = i;
        for (int i = n - 1; i > 0; i--) begin
            int j = int'($urandom_range(i, 0));
            int t = perm[i];
            perm[i] = perm[j];
            perm[j] = t;
        end
    endtask

    task automatic start(input int n);
        @(negedge clk);
        frame_len  = 13'(n);
        load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
    endtask

    // Feed values from..n-1 of perm; gaps inserts idle cycles. Checks done timing.
    task automatic feed(input int from, input int n, input bit gaps, input bit expect_done);
        for (int k = from; k < n; k++) begin
            if (gaps && ($urandom_range(3, 0) == 0)) begin
                seq_valid = 1'b0;
                @(negedge clk);
            end
            if (expect_done && k == n - 1) check("R5 done low before last value", int'(load_done), 0);
            seq_valid = 1'b1;
            seq_data  = 13'(perm[k]);
            @(negedge clk);
        end
        seq_valid = 1'b0;
        if (expect_done) check("R5 done one cycle after last value", int'(load_done), 1);
    endtask

    task automatic verify(input int n);
        for (int k = 0; k < n; k++) rd(k, 1'b0, perm[k], "R3 forward entry");
        for (int k = 0; k < n; k++) rd(perm[k], 1'b1, k, "R4 inverse of forward");
        rd_drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 load_done at reset", int'(load_done), 0);
        check("R1 rd_valid at reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Minimum frame length.
        shuffle(40);
        start(40);
        check("R2 done cleared by start", int'(load_done), 0);
        feed(0, 40, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check("R5 done holds", int'(load_done), 1);
        verify(40);

        // Stray values and illegal starts must not disturb anything.
        for (int i = 0; i < 3; i++) begin
            seq_valid = 1'b1;
            seq_data  = 13'(7 + i);
            @(negedge clk);
        end
        seq_valid = 1'b0;
        start(39);
        check("R2 short length ignored", int'(load_done), 1);
        start(5115);
        check("R2 long length ignored", int'(load_done), 1);
        seq_valid = 1'b1;
        seq_data  = 13'd3;
        @(negedge clk);
        seq_valid = 1'b0;
        for (int k = 0; k < 5; k++) rd(k, 1'b0, perm[k], "R7 forward unchanged");
        for (int k = 0; k < 5; k++) rd(k, 1'b1, perm.find_first_index(x) with (x == k)[0], "R7 inverse unchanged");
        rd_drain();

        // Mid length with idle gaps.
        shuffle(257);
        start(257);
        check("R2 done cleared by legal start", int'(load_done), 0);
        feed(0, 257, 1'b1, 1'b1);
        verify(257);

        // Interrupted load then restart.
        shuffle(60);
        start(60);
        feed(0, 10, 1'b0, 1'b0);
        check("R8 done low mid load", int'(load_done), 0);
        shuffle(60);
        start(60);
        feed(0, 60, 1'b1, 1'b1);
        verify(60);

        // Maximum frame length.
        shuffle(MAXN);
        start(MAXN);
        feed(0, MAXN, 1'b0, 1'b1);
        verify(MAXN);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule